// File: doc/BRIEF.md
# Tick Clock Channel with Fractional Divider

This block is one channel of a clock generator that works on tick pulses instead of real clocks. Ten source inputs each carry single-cycle enable pulses in the system clock domain. A control register picks one of them. A fractional divider thins the selected pulse stream, and the result leaves as a single-cycle pulse on `tick_out`. Software programs the channel through a small register port that holds a control word and a divider word.

The divisor has an integer field and a fractional field. Their widths are set per instance by `INT_W` and `FRAC_W`. The integer field always begins at bit 12 of the divider word, and the fractional field fills the bits directly below it. The two fields together form a divisor D. The output rate equals the source rate times 2^FRAC_W / D, and a first-order accumulator spreads the output pulses. An instance built with both widths zero has no divider and passes the selected source straight through.

Both pulse streams are plain single-cycle strobes with no back-pressure. `tick_out` cannot be stalled, and a pulse that nobody observes is gone. The register port is a plain strobe and address interface with no handshake.

Top module: `tick_clock_channel`

## Requirements
- R1: A synchronous active-high reset clears the control word, the divider word and the accumulator. While reset is held, `tick_out` stays low.
- R2: The control word is at address 0. The source select is in bits [3:0] and enable is in bit 4. Bit 7 is a busy flag that cannot be written. All other bits read 0, so a write of all ones reads back 0x9F.
- R3: The busy bit (bit 7 of the control word) always reads equal to the enable bit.
- R4: The divider word is at address 1. The integer part is in bits [12+INT_W-1:12] and the fraction is in bits [11:12-FRAC_W], and D is the value of those bits read as one number. All other bits read 0. With the default INT_W=4 and FRAC_W=2, this leaves bits [15:10].
- R5: Let S = 2^FRAC_W and D > S. The k-th selected source pulse after the last accumulator clear produces an output pulse exactly when floor(k·S/D) > floor((k-1)·S/D). If 0 < D ≤ S, every selected pulse produces an output pulse.
- R6: While D is 0, `tick_out` stays low.
- R7: While enable is 0, `tick_out` stays low.
- R8: Source select values 10 to 15 produce no output. Pulses on sources that are not selected have no effect on `tick_out`.
- R9: The accumulator clears on any write to the divider word. It also clears on a control write that changes the source select or writes enable as 0. A source pulse in the same cycle as such a write is dropped. A control write that keeps the select and sets enable does not clear the accumulator.
- R10: When INT_W = FRAC_W = 0, every selected source pulse appears on `tick_out` while the channel is enabled.
- R11: A register write takes effect at the next clock edge. A selected source pulse in cycle c shows up on `tick_out` in cycle c+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NSRC | Source tick pulses, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_addr | input | 1 | Write address: 0 control, 1 divider |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 1 | Read address: 0 control, 1 divider |
| reg_rd_data | output | 32 | Read data, combinational from the registers |
| tick_out | output | 1 | Divided output tick pulse |

## Verification
The hardest thing to observe from the ports is the hidden accumulator remainder. It shows up only in which of the later selected pulses come through. That matters most when a register write lands in the middle of a stream and must clear the accumulator, or must leave it alone. The stimulus sweeps every divisor value, and with it the select value, across the ten sources. Before each sweep step it leaves a remainder from the previous configuration. It drives irregular selected pulses under noise on the other sources, and it predicts every output cycle from the floor formula, counting pulses from the last clear.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int REG_W        = 32;
  localparam int SEL_W        = 4;
  localparam int CTL_SEL_LSB  = 0;
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_BUSY_BIT = 7;
  localparam int DIV_INT_LSB  = 12;

  typedef enum logic {
    ADDR_CTL = 1'b0,
    ADDR_DIV = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/tcc_regs.sv
module tcc_regs
  import tcc_pkg::*;
#(
  parameter int INT_W = 4,
  parameter int FRAC_W = 2,
  localparam int DW = INT_W + FRAC_W,
  localparam int DWS = (DW == 0) ? 1 : DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic [SEL_W-1:0] sel,
  output logic             en,
  output logic [DWS-1:0]   div,
  output logic             clr
);
  logic             wr_ctl, wr_div;
  logic [SEL_W-1:0] sel_new;
  logic             en_new;
  logic [DWS-1:0]   div_new;
  logic [REG_W-1:0] div_placed;

  assign wr_ctl  = wr && (wr_addr == ADDR_CTL);
  assign wr_div  = wr && (wr_addr == ADDR_DIV);
  assign sel_new = wr_data[CTL_SEL_LSB +: SEL_W];
  assign en_new  = wr_data[CTL_EN_BIT];

  generate
    if (DW > 0) begin : g_field
      assign div_new = wr_data[DIV_INT_LSB+INT_W-1 -: DW];
      always_comb begin
        div_placed = '0;
        div_placed[DIV_INT_LSB+INT_W-1 -: DW] = div;
      end
    end else begin : g_nofield
      assign div_new    = '0;
      assign div_placed = '0;
    end
  endgenerate

  // clear when the accumulator's meaning changes
  assign clr = wr_div || (wr_ctl && ((sel_new != sel) || !en_new));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
      en  <= 1'b0;
      div <= '0;
    end else begin
      if (wr_ctl) begin
        sel <= sel_new;
        en  <= en_new;
      end
      if (wr_div) div <= div_new;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTL) begin
      rd_data[CTL_SEL_LSB +: SEL_W] = sel;
      rd_data[CTL_EN_BIT]           = en;
      rd_data[CTL_BUSY_BIT]         = en;
    end else begin
      rd_data = div_placed;
    end
  end

  // R3
  busy_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_CTL) |-> (rd_data[CTL_BUSY_BIT] == en));

  // R11
  ctl_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (en == $past(en_new)) && (sel == $past(sel_new)));
endmodule

// File: rtl/tcc_src_pick.sv
module tcc_src_pick
  import tcc_pkg::*;
#(
  parameter int NSRC = 10
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  src,
  output logic             hit
);
  logic [NSRC-1:0] match;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign match[i] = (sel == SEL_W'(i)) && src[i];
    end
  endgenerate

  assign hit = |match;

  // R8
  pick_onehot_chk: assert final ($onehot0(match));
endmodule

// File: rtl/tcc_frac_div.sv
module tcc_frac_div #(
  parameter int INT_W = 4,
  parameter int FRAC_W = 2,
  localparam int DW = INT_W + FRAC_W,
  localparam int DWS = (DW == 0) ? 1 : DW,
  localparam int AW = DW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           clr,
  input  logic [DWS-1:0] div,
  input  logic           hit,
  output logic           tick
);
  generate
    if (DW == 0) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= en && !clr && hit;
      end
    end else begin : g_div
      localparam logic [AW-1:0] STEP = AW'(1) << FRAC_W;
      logic [AW-1:0] acc, sum, divx;
      logic          idle;

      assign divx = AW'(div);
      assign sum  = acc + STEP;
      assign idle = clr || !en || (divx == '0);

      always_ff @(posedge clk) begin
        if (rst) begin
          acc  <= '0;
          tick <= 1'b0;
        end else if (idle) begin
          acc  <= '0;
          tick <= 1'b0;
        end else if (hit) begin
          if (divx <= STEP) begin
            acc  <= '0;
            tick <= 1'b1;
          end else if (sum >= divx) begin
            acc  <= sum - divx;
            tick <= 1'b1;
          end else begin
            acc  <= sum;
            tick <= 1'b0;
          end
        end else begin
          tick <= 1'b0;
        end
      end

      // R5
      acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (acc == '0) || (acc < divx));

      // R6
      zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (divx == '0) |=> !tick);
    end
  endgenerate

  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);
endmodule

// File: rtl/tick_clock_channel.sv
module tick_clock_channel
  import tcc_pkg::*;
#(
  parameter int NSRC = 10,
  parameter int INT_W = 4,
  parameter int FRAC_W = 2,
  localparam int DW = INT_W + FRAC_W,
  localparam int DWS = (DW == 0) ? 1 : DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             reg_wr,
  input  logic             reg_wr_addr,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             reg_rd_addr,
  output logic [REG_W-1:0] reg_rd_data,
  output logic             tick_out
);
  logic [SEL_W-1:0] sel;
  logic             en;
  logic [DWS-1:0]   div;
  logic             clr;
  logic             hit;

  tcc_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr(reg_wr), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .sel(sel), .en(en), .div(div), .clr(clr)
  );

  tcc_src_pick #(.NSRC(NSRC)) u_pick (
    .sel(sel), .src(src_tick), .hit(hit)
  );

  tcc_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst(rst), .en(en), .clr(clr),
    .div(div), .hit(hit), .tick(tick_out)
  );

  // R8
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !tick_out);
endmodule

// File: tb/tick_clock_channel_test.sv
module tick_clock_channel_test;
  localparam int NSRC = 10;
  localparam int INT_W = 4;
  localparam int FRAC_W = 2;
  localparam int S = 1 << FRAC_W;
  localparam int DMAX = (1 << (INT_W + FRAC_W)) - 1;
  localparam logic [31:0] DIV_MASK = 32'h0000FC00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NSRC-1:0] src_tick = '0;
  logic        reg_wr = 1'b0;
  logic        reg_wr_addr = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        reg_rd_addr = 1'b0;
  logic [31:0] rd_main, rd_pass;
  logic        tick_main, tick_pass;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_sel = 0;
  bit m_en = 0;
  int m_div = 0;
  int k = 0;

  always #2.5 clk = ~clk;

  tick_clock_channel #(.NSRC(NSRC), .INT_W(INT_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .reg_wr(reg_wr), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(rd_main), .tick_out(tick_main)
  );

  tick_clock_channel #(.NSRC(NSRC), .INT_W(0), .FRAC_W(0)) uut_pass (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .reg_wr(reg_wr), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(rd_pass), .tick_out(tick_pass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R9 R11: write lands on one edge, model updates clear state
  task automatic wreg(input logic addr, input logic [31:0] data);
    int nsel;
    bit nen;
    src_tick = '0;
    reg_wr = 1'b1; reg_wr_addr = addr; reg_wr_data = data;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    if (addr == 1'b1) begin
      m_div = int'((data & DIV_MASK) >> 10);
      k = 0;
    end else begin
      nsel = int'(data[3:0]);
      nen = data[4];
      if (nsel != m_sel || !nen) k = 0;
      m_sel = nsel; m_en = nen;
    end
  endtask

  task automatic step(input logic [NSRC-1:0] pat);
    bit selhit, exp_m;
    string req;
    src_tick = pat;
    @(posedge clk); @(negedge clk);
    selhit = m_en && (m_sel < NSRC) && pat[m_sel];
    exp_m = 1'b0;
    if (!m_en) req = "R7";
    else if (m_sel >= NSRC) req = "R8";
    else if (m_div == 0) req = "R6";
    else req = "R5";
    if (selhit && m_div != 0) begin
      k++;
      if (m_div <= S) exp_m = 1'b1;
      else exp_m = ((k * S) / m_div) > (((k - 1) * S) / m_div);
    end
    if (!m_en || m_div == 0) k = 0;
    chk(req, 32'(tick_main), 32'(exp_m));
    chk("R10", 32'(tick_pass), 32'(selhit));
  endtask

  function automatic logic [NSRC-1:0] pattern(input int i, input int seed, input int sel);
    logic [NSRC-1:0] p;
    p = NSRC'((i * 37 + seed * 11) ^ (i << 3));
    if (sel < NSRC) p[sel] = ((i % 3) != 1) || ((i % 7) == 4);
    return p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    src_tick = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: tick must stay low while reset is held even with sources active
    chk("R1", 32'(tick_main), 32'd0);
    rst = 1'b0; src_tick = '0;
    reg_rd_addr = 1'b0; #1;
    chk("R1", rd_main, 32'd0);
    reg_rd_addr = 1'b1; #1;
    chk("R1", rd_main, 32'd0);
    chk("R1", 32'(tick_main), 32'd0);
    @(negedge clk);

    // R2 R3: control readback layout and busy mirror
    wreg(1'b0, 32'hFFFF_FFFF);
    reg_rd_addr = 1'b0; #1;
    chk("R2", rd_main, 32'h0000_009F);
    wreg(1'b0, 32'h0000_0003);
    reg_rd_addr = 1'b0; #1;
    chk("R3", rd_main, 32'h0000_0003);
    wreg(1'b0, 32'h0000_0015);
    reg_rd_addr = 1'b0; #1;
    chk("R3", rd_main, 32'h0000_0095);
    // R4: divider field placement
    wreg(1'b1, 32'hFFFF_FFFF);
    reg_rd_addr = 1'b1; #1;
    chk("R4", rd_main, DIV_MASK);
    chk("R4", rd_pass, 32'd0);
    wreg(1'b1, 32'h1234_5678);
    reg_rd_addr = 1'b1; #1;
    chk("R4", rd_main, 32'h1234_5678 & DIV_MASK);
    @(negedge clk);

    // R5 R6 R8 R9 R10 R11: sweep every divisor, rotating the source
    for (int d = 0; d <= DMAX; d++) begin
      int s;
      s = d % NSRC;
      wreg(1'b0, 32'h10 | 32'(s));
      wreg(1'b1, 32'(d) << 10);
      for (int i = 0; i < 24; i++) step(pattern(i, d, s));
    end

    // R9: rewrite control with same select keeps remainder, changing select clears it
    wreg(1'b1, 32'(7) << 10);
    wreg(1'b0, 32'h12);
    for (int i = 0; i < 3; i++) step(10'b00_0000_0100);
    wreg(1'b0, 32'h12);
    for (int i = 0; i < 5; i++) step(10'b00_0000_0100);
    wreg(1'b0, 32'h13);
    wreg(1'b0, 32'h12);
    for (int i = 0; i < 8; i++) step(10'b00_0000_0100);
    wreg(1'b0, 32'h02);
    wreg(1'b0, 32'h12);
    for (int i = 0; i < 8; i++) step(10'b00_0000_0100);

    // R7: disabled channel, all sources pulsing
    wreg(1'b1, 32'(5) << 10);
    wreg(1'b0, 32'h04);
    for (int i = 0; i < 12; i++) step('1);

    // R8: unused select codes
    for (int c = NSRC; c < 16; c++) begin
      wreg(1'b0, 32'h10 | 32'(c));
      for (int i = 0; i < 6; i++) step('1);
    end

    // R8: only unselected sources pulse
    wreg(1'b0, 32'h15);
    for (int i = 0; i < 10; i++) step(10'b11_1101_1111);

    src_tick = '0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule